// File: doc/BRIEF.md
# Serial Flash Command Decoder

This block is the command front end of a serial NOR flash slave. A serializer outside the block delivers whole bytes with a valid strobe, while an active-low chip select frames each transaction. The first byte of every frame is taken as an opcode. For addressed opcodes the decoder gathers address bytes, most significant first, and then any dummy bytes. It then starts a read, a page program or an erase by pulsing a one-cycle operation strobe. The strobe carries the operation kind, the start address and, for erases, the length in bytes.

The decoder also keeps four mode flags: write enable, four-byte addressing, reset enable and quad enable. Single-byte commands change these flags, and so does a write-status command, which the write-enable flag gates. Some opcodes always take a four-byte address. The others take three or four address bytes according to the addressing flag. The dummy phase of the multi-wire reads is sized by counting in units of the wire width. During a read or program phase, the storage array and the data path consume the following bytes of the frame, using the phase output to do so.

Top module: `sfc_decoder`

## Requirements
- R1: After reset, phase is idle (0), op_valid is 0 and the wr_en, addr4_mode, rst_en and quad_en flags are all 0.
- R2: Opcodes 0x12, 0x13, 0x21, 0xDC and 0xEC always take 4 address bytes. Every other addressed opcode takes 4 when addr4_mode is 1 and 3 when it is 0.
- R3: Address bytes are assembled most significant byte first. With 3 address bytes, bits 31:24 of op_addr are 0.
- R4: Dummy bytes follow the address. 0x0B, 0x3B and 0x6B take 1. 0xBB takes DUMMY_CYC/4 (2 at default). 0xEB and 0xEC take DUMMY_CYC/2, which is 5 at default, so 0xEB needs 8 bytes in three-byte mode and 9 in four-byte mode. No operation is issued before the last of these bytes.
- R5: op_valid pulses for one cycle in the clock cycle after the last needed byte is accepted. Read opcodes (0x03, 0x13, 0x0B, 0x3B, 0x6B, 0xBB, 0xEB, 0xEC) give op_kind 1 and phase 2. Program opcodes (0x02, 0x12, 0xA2, 0x32) give op_kind 2 and phase 3. Erase opcodes give op_kind 3 and return phase to idle (0). Reads and programs report op_len 0.
- R6: op_len is 4096 for 0x20 and 0x21, 32768 for 0x52, and SECTOR_BYTES for 0xD8 and 0xDC.
- R7: 0xC7 issues an erase at once, with op_addr 0 and op_len DEVICE_BYTES, and takes no address bytes.
- R8: 0xB7 sets addr4_mode and 0xE9 clears it. 0x06 sets wr_en and 0x04 clears it.
- R9: Write-status 0x01 is accepted only while wr_en is 1. Its one data byte loads quad_en from bit QE_BIT (6), and the command clears wr_en. With wr_en at 0, the command and its data have no effect.
- R10: 0x66 sets rst_en. 0x99 while rst_en is 1 clears wr_en, rst_en and quad_en and returns phase to idle. 0x99 while rst_en is 0 has no effect.
- R11: cs_n high at any point aborts collection and returns phase to idle, with no operation issued. The first byte of the next frame is decoded as an opcode.
- R12: An unknown opcode puts phase into skip (4). All bytes up to cs_n high are then ignored, and every flag stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select |
| rx_valid | input | 1 | rx_byte holds a received byte this cycle |
| rx_byte | input | 8 | Received byte |
| op_valid | output | 1 | One-cycle operation strobe |
| op_kind | output | 2 | 0 none, 1 read, 2 program, 3 erase |
| op_addr | output | 32 | Operation start address |
| op_len | output | 32 | Erase length in bytes, 0 otherwise |
| phase | output | 3 | 0 idle, 1 collect, 2 read, 3 program, 4 skip |
| wr_en | output | 1 | Write-enable flag |
| addr4_mode | output | 1 | Four-byte addressing flag |
| rst_en | output | 1 | Reset-enable flag |
| quad_en | output | 1 | Quad-enable flag |

## Verification
A wrong byte count or a wrong address-width choice shows up on the last byte of the very frame that triggered it. The strobe then comes one or more bytes early or late, and op_addr carries shifted or missing bytes. A wrong flag is visible on its port one cycle after the byte that should have set or cleared it. It also alters the address length of the next frame that depends on it. A failed abort shows as a phase other than idle one cycle after cs_n rises, or as a stray strobe.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_COLLECT = 3'd1,
        PH_READ    = 3'd2,
        PH_PROG    = 3'd3,
        PH_SKIP    = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        OPK_NONE  = 2'd0,
        OPK_READ  = 2'd1,
        OPK_PROG  = 2'd2,
        OPK_ERASE = 2'd3
    } opkind_e;

    typedef enum logic [3:0] {
        CL_UNK, CL_READ, CL_PROG, CL_ERASE, CL_CHIP, CL_WREN, CL_WRDI,
        CL_EN4, CL_EX4, CL_WRSR, CL_RSTEN, CL_RST
    } opclass_e;

endpackage

// File: rtl/sfc_opclass.sv
module sfc_opclass
    import sfc_pkg::*;
#(
    parameter int DUMMY_CYC = 10,
    parameter int CW        = 4
) (
    input  logic [7:0]    opc,
    output opclass_e      cls,
    output logic          force4,
    output logic [CW-1:0] extra
);
    // dummy bytes: dummy cycles times wire width, over eight bits per byte
    localparam int DUAL_EXTRA = DUMMY_CYC / 4;
    localparam int QUAD_EXTRA = DUMMY_CYC / 2;

    always_comb begin
        cls    = CL_UNK;
        force4 = 1'b0;
        extra  = '0;
        case (opc)
            8'h03: cls = CL_READ;
            8'h13: begin cls = CL_READ; force4 = 1'b1; end
            8'h0B, 8'h3B, 8'h6B: begin cls = CL_READ; extra = CW'(1); end
            8'hBB: begin cls = CL_READ; extra = CW'(DUAL_EXTRA); end
            8'hEB: begin cls = CL_READ; extra = CW'(QUAD_EXTRA); end
            8'hEC: begin cls = CL_READ; extra = CW'(QUAD_EXTRA); force4 = 1'b1; end
            8'h02, 8'hA2, 8'h32: cls = CL_PROG;
            8'h12: begin cls = CL_PROG; force4 = 1'b1; end
            8'h20, 8'h52, 8'hD8: cls = CL_ERASE;
            8'h21, 8'hDC: begin cls = CL_ERASE; force4 = 1'b1; end
            8'hC7: cls = CL_CHIP;
            8'h06: cls = CL_WREN;
            8'h04: cls = CL_WRDI;
            8'hB7: cls = CL_EN4;
            8'hE9: cls = CL_EX4;
            8'h01: cls = CL_WRSR;
            8'h66: cls = CL_RSTEN;
            8'h99: cls = CL_RST;
            default: cls = CL_UNK;
        endcase
    end
endmodule

// File: rtl/sfc_erase_len.sv
module sfc_erase_len #(
    parameter int unsigned SECTOR_BYTES = 65536,
    parameter int unsigned DEVICE_BYTES = 32'h0200_0000
) (
    input  logic [7:0]  opc,
    output logic [31:0] len
);
    localparam logic [31:0] LEN_SMALL = 32'd4096;
    localparam logic [31:0] LEN_MID   = 32'd32768;

    always_comb begin
        case (opc)
            8'h20, 8'h21: len = LEN_SMALL;
            8'h52:        len = LEN_MID;
            8'hD8, 8'hDC: len = SECTOR_BYTES;
            8'hC7:        len = DEVICE_BYTES;
            default:      len = '0;
        endcase
    end
endmodule

// File: rtl/sfc_decoder.sv
module sfc_decoder
    import sfc_pkg::*;
#(
    parameter int unsigned SECTOR_BYTES = 65536,
    parameter int unsigned DEVICE_BYTES = 32'h0200_0000,
    parameter int          DUMMY_CYC    = 10,
    parameter int          QE_BIT       = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic        op_valid,
    output logic [1:0]  op_kind,
    output logic [31:0] op_addr,
    output logic [31:0] op_len,
    output logic [2:0]  phase,
    output logic        wr_en,
    output logic        addr4_mode,
    output logic        rst_en,
    output logic        quad_en
);
    localparam int MAX_NEED = 4 + DUMMY_CYC / 2 + 1;
    localparam int CW       = $clog2(MAX_NEED + 1);

    typedef struct packed {
        phase_e        ph;
        logic [7:0]    opc;
        logic [CW-1:0] need;
        logic [CW-1:0] cnt;
        logic [2:0]    nad;
        logic [31:0]   addr;
        logic          wen;
        logic          a4;
        logic          ren;
        logic          qen;
        logic          ov;
        opkind_e       kind;
        logic [31:0]   oaddr;
        logic [31:0]   olen;
    } st_t;

    st_t q, d;

    logic [7:0]    opc_sel;
    opclass_e      cls;
    logic          force4;
    logic [CW-1:0] extra;
    logic [31:0]   elen;

    // decode the live byte in idle, the stored opcode otherwise
    assign opc_sel = (q.ph == PH_IDLE) ? rx_byte : q.opc;

    sfc_opclass #(.DUMMY_CYC(DUMMY_CYC), .CW(CW)) i_opclass (
        .opc(opc_sel), .cls(cls), .force4(force4), .extra(extra)
    );

    sfc_erase_len #(.SECTOR_BYTES(SECTOR_BYTES), .DEVICE_BYTES(DEVICE_BYTES)) i_elen (
        .opc(opc_sel), .len(elen)
    );

    always_comb begin
        logic [2:0] nad_new;
        d    = q;
        d.ov = 1'b0;
        nad_new = (force4 || q.a4) ? 3'd4 : 3'd3;
        if (cs_n) begin
            d.ph = PH_IDLE;
        end else if (rx_valid) begin
            case (q.ph)
                PH_IDLE: begin
                    d.opc  = rx_byte;
                    d.cnt  = '0;
                    d.addr = '0;
                    d.nad  = nad_new;
                    d.need = CW'(nad_new) + extra;
                    d.ph   = PH_SKIP;
                    case (cls)
                        CL_READ, CL_PROG, CL_ERASE: d.ph = PH_COLLECT;
                        CL_CHIP: begin
                            d.ov    = 1'b1;
                            d.kind  = OPK_ERASE;
                            d.oaddr = '0;
                            d.olen  = elen;
                            d.ph    = PH_IDLE;
                        end
                        CL_WREN: d.wen = 1'b1;
                        CL_WRDI: d.wen = 1'b0;
                        CL_EN4:  d.a4  = 1'b1;
                        CL_EX4:  d.a4  = 1'b0;
                        CL_WRSR: if (q.wen) begin
                            d.ph   = PH_COLLECT;
                            d.nad  = 3'd0;
                            d.need = CW'(1);
                        end
                        CL_RSTEN: d.ren = 1'b1;
                        CL_RST: if (q.ren) begin
                            d.wen = 1'b0;
                            d.ren = 1'b0;
                            d.qen = 1'b0;
                            d.ph  = PH_IDLE;
                        end
                        default: ;
                    endcase
                end
                PH_COLLECT: begin
                    d.cnt = q.cnt + CW'(1);
                    if (q.cnt < CW'(q.nad))
                        d.addr = {q.addr[23:0], rx_byte};
                    if (d.cnt == q.need) begin
                        case (cls)
                            CL_WRSR: begin
                                d.qen = rx_byte[QE_BIT];
                                d.wen = 1'b0;
                                d.ph  = PH_SKIP;
                            end
                            CL_READ: begin
                                d.ov = 1'b1; d.kind = OPK_READ;
                                d.oaddr = d.addr; d.olen = '0; d.ph = PH_READ;
                            end
                            CL_PROG: begin
                                d.ov = 1'b1; d.kind = OPK_PROG;
                                d.oaddr = d.addr; d.olen = '0; d.ph = PH_PROG;
                            end
                            CL_ERASE: begin
                                d.ov = 1'b1; d.kind = OPK_ERASE;
                                d.oaddr = d.addr; d.olen = elen; d.ph = PH_IDLE;
                            end
                            default: d.ph = PH_SKIP;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, kind: OPK_NONE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign op_valid   = q.ov;
    assign op_kind    = q.kind;
    assign op_addr    = q.oaddr;
    assign op_len     = q.olen;
    assign phase      = q.ph;
    assign wr_en      = q.wen;
    assign addr4_mode = q.a4;
    assign rst_en     = q.ren;
    assign quad_en    = q.qen;

    // frame end always lands in idle with no strobe
    assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (phase == PH_IDLE && !op_valid));

    // an erase strobe leaves the decoder idle; a read strobe enters the read phase
    assert_erase_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == OPK_ERASE) |-> phase == PH_IDLE);
    assert_read_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == OPK_READ) |-> phase == PH_READ);

    // strobes only follow a byte taken inside a frame
    assert_op_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_valid) |-> $past(!cs_n && rx_valid));

    // quad enable can only rise while write enable was held
    assert_quad_wen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(quad_en) |-> $past(wr_en));

    // skipped bytes never touch a flag
    assert_skip_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SKIP) |=> $stable({wr_en, addr4_mode, rst_en, quad_en}));

    // non-erase operations carry no length
    assert_len_nonerase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind != OPK_ERASE) |-> op_len == 32'd0);
endmodule

// File: tb/test_sfc_decoder.sv
`timescale 1ns/1ps
module test_sfc_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        op_valid;
    logic [1:0]  op_kind;
    logic [31:0] op_addr, op_len;
    logic [2:0]  phase;
    logic        wr_en, addr4_mode, rst_en, quad_en;

    int total = 0;
    int bad   = 0;
    int pulses = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    sfc_decoder i_sfc_decoder (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr), .op_len(op_len),
        .phase(phase), .wr_en(wr_en), .addr4_mode(addr4_mode), .rst_en(rst_en),
        .quad_en(quad_en)
    );

    always @(posedge clk) if (op_valid) pulses <= pulses + 1;

    // opcode, forced four-byte address, dummy bytes, kind, erase length
    localparam int N = 17;
    localparam logic [7:0]  T_OPC [N] = '{8'h03, 8'h13, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB, 8'hEC,
                                          8'h02, 8'h12, 8'hA2, 8'h32, 8'h20, 8'h21, 8'h52, 8'hD8, 8'hDC};
    localparam logic        T_F4  [N] = '{0, 1, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 1, 0, 0, 1};
    localparam int          T_EX  [N] = '{0, 0, 1, 1, 1, 2, 5, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    localparam logic [1:0]  T_KND [N] = '{1, 1, 1, 1, 1, 1, 1, 1, 2, 2, 2, 2, 3, 3, 3, 3, 3};
    localparam logic [31:0] T_LEN [N] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
                                          4096, 4096, 32768, 65536, 65536};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic open_frame();
        @(negedge clk);
        cs_n   = 1'b0;
        pulses = 0;
    endtask

    task automatic close_frame();
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run(input logic [7:0] opc, input int nb);
        open_frame();
        put(opc);
        for (int i = 0; i < nb; i++)
            put((i < 4) ? 8'(8'h11 * (i + 1)) : 8'hA5);
    endtask

    task automatic cmd(input logic [7:0] opc);
        run(opc, 0);
        close_frame();
    endtask

    initial begin
        #(8ns * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(phase == 3'd0 && !op_valid, "R1 phase/strobe", {28'd0, op_valid, phase}, 0);
        chk({wr_en, addr4_mode, rst_en, quad_en} == 4'b0, "R1 flags",
            {wr_en, addr4_mode, rst_en, quad_en}, 0);

        // table walk in both address modes: R2 R3 R4 R5 R6
        for (int mode = 0; mode < 2; mode++) begin
            cmd(mode ? 8'hB7 : 8'hE9);
            chk(addr4_mode == mode[0], "R8 addr mode", addr4_mode, mode);
            for (int i = 0; i < N; i++) begin
                int na;
                int nb;
                logic [31:0] ea;
                logic [2:0]  eph;
                na  = (T_F4[i] || mode[0]) ? 4 : 3;
                nb  = na + T_EX[i];
                ea  = (na == 4) ? 32'h11223344 : 32'h00112233;
                eph = (T_KND[i] == 2'd1) ? 3'd2 : (T_KND[i] == 2'd2) ? 3'd3 : 3'd0;
                run(T_OPC[i], nb);
                chk(op_valid, "R5 strobe on last byte", op_valid, 1);
                chk(pulses == 0, "R4 R2 no early strobe", pulses, 0);
                chk(op_kind == T_KND[i], "R5 kind", op_kind, T_KND[i]);
                chk(op_addr == ea, "R3 R2 address", op_addr, ea);
                chk(op_len == T_LEN[i], "R6 length", op_len, T_LEN[i]);
                chk(phase == eph, "R5 phase", phase, eph);
                close_frame();
            end
        end

        // R7 chip erase
        run(8'hC7, 0);
        chk(op_valid && op_kind == 2'd3, "R7 chip erase strobe", op_kind, 3);
        chk(op_addr == 0 && op_len == 32'h0200_0000, "R7 chip erase len", op_len, 32'h0200_0000);
        close_frame();

        // R9 write-status without write enable ignored
        cmd(8'h04);
        chk(!wr_en, "R8 write disable", wr_en, 0);
        open_frame(); put(8'h01); put(8'h40); close_frame();
        chk(!quad_en, "R9 gated write-status", quad_en, 0);
        cmd(8'h06);
        chk(wr_en, "R8 write enable", wr_en, 1);
        open_frame(); put(8'h01); put(8'h40); close_frame();
        chk(quad_en && !wr_en, "R9 write-status sets quad, clears wen",
            {quad_en, wr_en}, 2'b10);

        // R11 abort mid address, then a fresh frame decodes its opcode
        open_frame(); put(8'h03); put(8'h11); close_frame();
        chk(pulses == 0 && phase == 3'd0, "R11 abort", pulses, 0);
        run(8'h03, 4);
        chk(op_valid && op_addr == 32'h11223344, "R11 fresh opcode after abort", op_addr, 32'h11223344);
        close_frame();

        // R12 unknown opcode swallows the rest of the frame
        open_frame(); put(8'h5A); put(8'h06); put(8'hE9);
        chk(phase == 3'd4, "R12 skip phase", phase, 4);
        close_frame();
        chk(!wr_en && addr4_mode && pulses == 0, "R12 flags unchanged",
            {wr_en, addr4_mode}, 2'b01);

        // R10 reset sequence
        cmd(8'h06);
        cmd(8'h99);
        chk(wr_en && quad_en, "R10 reset without enable ignored", {wr_en, quad_en}, 2'b11);
        cmd(8'h66);
        chk(rst_en, "R10 reset enable", rst_en, 1);
        cmd(8'h99);
        chk({wr_en, rst_en, quad_en} == 3'b0 && addr4_mode, "R10 reset clears flags",
            {wr_en, rst_en, quad_en}, 0);
        chk(phase == 3'd0, "R10 reset idle", phase, 0);

        cmd(8'hE9);
        chk(!addr4_mode, "R8 exit four-byte", addr4_mode, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule